// File: doc/BRIEF.md
# Multi-ADC Global Sync Trigger Controller

This block decides when sampling begins on a small array of converter modules, each with four sample sequencers. Software programs each module through two registers. The enable register turns individual sequencers on and carries a DMA-request enable for each one. The initiate register asks for sampling to start on chosen sequencers. A start request can fire at once, or it can be held until a global release. A release write in any one module lets every holding module fire in the same clock cycle. The block drives a one-cycle start pulse per sequencer and keeps a busy flag for each sequencer until a done input reports that the fixed-latency conversion has finished.

Held start bits stay readable in the initiate register. They clear when the release fires or when their sequencer is disabled. After a release, the hold and release flags of each module that took part clear by themselves, so the next synchronized start needs a new arm and release. A sequencer set for continuous triggering ignores the hold. It starts as soon as it is enabled and starts again each time its done input arrives. A start that reaches a sequencer which is already busy sets a sticky overrun flag, which is cleared by writing one to it.

Top module: `gsync_trig_ctrl`

## Requirements
- R1: After reset, every start pulse, sequencer busy flag and module busy flag is low, and all three registers of every module read 0.
- R2: An initiate start bit for a sequencer whose enable bit is clear has no effect. No pulse is produced, and the bit does not appear in the initiate register.
- R3: An initiate write (register select 1) with bit 31 and bit 27 both clear starts each enabled sequencer n named in bits 3:0. The start pulse is high in the cycle after the write edge, and the busy flag rises on that same edge.
- R4: An initiate write with bit 27 (hold) or bit 31 (release) set arms its enabled start bits without pulsing. The initiate register then reads the armed bits in 3:0, the hold flag in bit 27 and the release flag in bit 31.
- R5: A release write (bit 31) to any module fires all armed starts in every module whose hold or release flag is set, including start bits carried by the release write itself. They all fire in one cycle, two edges after the release write edge.
- R6: When a release fires, the armed bits and the hold and release flags of each module that took part read 0 afterwards.
- R7: Disabling a sequencer clears its armed bit, and a later release then produces no pulse on it.
- R8: The enable register (select 0) holds sequencer n's enable in bit n and its DMA enable in bit n+8, and reads back as written. For example, 0x101 enables sequencer 0 together with its DMA request.
- R9: A sequencer with its continuous-mode input high pulses on the edge that enables it, even while its module holds. It pulses again one edge after each done input clears its busy flag, for as long as it stays enabled.
- R10: A sequencer's busy flag clears on the edge where its done input is high. A module's busy output is the OR of its sequencers' busy flags.
- R11: A start that reaches a busy sequencer still pulses and sets that sequencer's overrun bit n in the status register (select 2). Writing one to the bit clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_mod | input | MW | Module addressed by the write |
| wr_reg | input | 2 | Register select: 0 enable, 1 initiate, 2 overrun status |
| wr_data | input | 32 | Write data |
| rd_mod | input | MW | Module addressed by the read |
| rd_reg | input | 2 | Register select for the read |
| rd_data | output | 32 | Read data, combinational |
| cont_mode | input | NM*NS | Continuous-trigger mode per sequencer, index m*NS+n |
| seq_done | input | NM*NS | Conversion finished, per sequencer |
| start_pulse | output | NM*NS | One-cycle sample-start pulse per sequencer |
| seq_busy | output | NM*NS | Sequencer conversion in progress |
| mod_busy | output | NM | OR of a module's sequencer busy flags |

## Verification
Two functions can fall on the same clock edge: the global release of held starts, and an immediate start written directly into another module. The bench places a no-hold initiate write to module 1 so that its edge is the one on which a release, triggered earlier from module 0, fires. Both starts must then show up together in one compared start-pulse vector, with no stray bit and with neither start delayed to the next cycle. Continuous restarts and overrun pulses are mixed in the same way and judged against the queued vector for their cycle.

// File: rtl/gsync_pkg.sv
package gsync_pkg;
  localparam int GSYNC_BIT = 31;
  localparam int WAIT_BIT  = 27;
  localparam int DMA_OFS   = 8;
  localparam int MAX_SEQ   = 8;

  typedef enum logic [1:0] {
    REG_ACT  = 2'd0,
    REG_INIT = 2'd1,
    REG_OVR  = 2'd2
  } reg_sel_e;

  function automatic logic [31:0] pack_act(input logic [MAX_SEQ-1:0] en,
                                           input logic [MAX_SEQ-1:0] dma);
    logic [31:0] r;
    r = '0;
    r[MAX_SEQ-1:0] = en;
    r[DMA_OFS +: MAX_SEQ] = dma;
    return r;
  endfunction

  function automatic logic [31:0] pack_init(input logic [MAX_SEQ-1:0] armed,
                                            input logic hold,
                                            input logic gsync);
    logic [31:0] r;
    r = '0;
    r[MAX_SEQ-1:0] = armed;
    r[WAIT_BIT] = hold;
    r[GSYNC_BIT] = gsync;
    return r;
  endfunction
endpackage

// File: rtl/gsync_seq_slot.sv
module gsync_seq_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic en_q,
  input  logic en_d,
  input  logic cont,
  input  logic imm_start,
  input  logic arm_set,
  input  logic rel_i,
  input  logic done,
  input  logic ovr_clr,
  output logic armed_q,
  output logic pulse_q,
  output logic busy_q,
  output logic ovr_q
);
  logic held_fire;
  logic cont_fire;
  logic req;
  logic ovr_hit;

  assign held_fire = rel_i & armed_q & en_d;
  assign cont_fire = cont & en_d & ~busy_q;
  assign req       = imm_start | held_fire | cont_fire;
  assign ovr_hit   = req & busy_q & ~done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      pulse_q <= 1'b0;
      busy_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      armed_q <= en_d & ((armed_q & ~rel_i) | arm_set);
      pulse_q <= req;
      busy_q  <= req | (busy_q & ~done);
      ovr_q   <= ovr_hit | (ovr_q & ~ovr_clr);
    end
  end

  // R2
  start_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> en_q);
  // R7
  held_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !armed_q);
  // R3
  busy_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> busy_q);
  // R10
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(done));
  // R11
  ovr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(busy_q));
endmodule

// File: rtl/gsync_module.sv
module gsync_module
  import gsync_pkg::*;
#(
  parameter int NS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hit,
  input  logic [1:0]    wr_reg,
  input  logic [NS-1:0] wr_start,
  input  logic [NS-1:0] wr_dma,
  input  logic          wr_wait,
  input  logic          wr_gs,
  input  logic [NS-1:0] cont,
  input  logic [NS-1:0] done,
  input  logic          rel_in,
  output logic          gs_flag,
  output logic [31:0]   act_rd,
  output logic [31:0]   init_rd,
  output logic [31:0]   ovr_rd,
  output logic [NS-1:0] pulse,
  output logic [NS-1:0] busy,
  output logic          mod_busy
);
  logic [NS-1:0] en_q, en_d, dma_q, armed, ovr, imm, arm, ovr_clr;
  logic act_wr, init_wr, ovr_wr, hold, wait_q, gs_q, rel;
  logic [MAX_SEQ-1:0] en8, dma8, armed8, ovr8;

  assign act_wr  = wr_hit && (wr_reg == REG_ACT);
  assign init_wr = wr_hit && (wr_reg == REG_INIT);
  assign ovr_wr  = wr_hit && (wr_reg == REG_OVR);
  assign hold    = wr_wait | wr_gs;
  assign en_d    = act_wr ? wr_start : en_q;
  assign imm     = (init_wr && !hold) ? (wr_start & en_q) : '0;
  assign arm     = (init_wr && hold)  ? (wr_start & en_q) : '0;
  assign ovr_clr = ovr_wr ? wr_start : '0;
  assign rel     = rel_in & (wait_q | gs_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      dma_q  <= '0;
      wait_q <= 1'b0;
      gs_q   <= 1'b0;
    end else begin
      en_q   <= en_d;
      if (act_wr) dma_q <= wr_dma;
      wait_q <= (init_wr & wr_wait) | (wait_q & ~rel);
      gs_q   <= (init_wr & wr_gs)   | (gs_q & ~rel);
    end
  end

  for (genvar n = 0; n < NS; n++) begin : g_slot
    gsync_seq_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_q     (en_q[n]),
      .en_d     (en_d[n]),
      .cont     (cont[n]),
      .imm_start(imm[n]),
      .arm_set  (arm[n]),
      .rel_i    (rel),
      .done     (done[n]),
      .ovr_clr  (ovr_clr[n]),
      .armed_q  (armed[n]),
      .pulse_q  (pulse[n]),
      .busy_q   (busy[n]),
      .ovr_q    (ovr[n])
    );
  end

  always_comb begin
    en8 = '0;  en8[NS-1:0] = en_q;
    dma8 = '0; dma8[NS-1:0] = dma_q;
    armed8 = '0; armed8[NS-1:0] = armed;
    ovr8 = '0; ovr8[NS-1:0] = ovr;
  end

  assign act_rd   = pack_act(en8, dma8);
  assign init_rd  = pack_init(armed8, wait_q, gs_q);
  assign ovr_rd   = {{(32-MAX_SEQ){1'b0}}, ovr8};
  assign gs_flag  = gs_q;
  assign mod_busy = |busy;

  // R6
  rel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel && !init_wr) |=> (!wait_q && !gs_q && armed == '0));
  // R4
  hold_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_wr && hold && !rel && cont == '0 && imm == '0) |=> (pulse == '0));
endmodule

// File: rtl/gsync_release.sv
module gsync_release #(
  parameter int NM = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NM-1:0] gs_flags,
  output logic          rel_q
);
  logic any_gs;
  assign any_gs = |gs_flags;

  always_ff @(posedge clk) begin
    if (!rst_n) rel_q <= 1'b0;
    else        rel_q <= any_gs & ~rel_q;
  end

  // R5
  rel_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_q |=> !rel_q);
  // R5
  rel_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_q |-> $past(any_gs));
endmodule

// File: rtl/gsync_trig_ctrl.sv
module gsync_trig_ctrl
  import gsync_pkg::*;
#(
  parameter int NM = 2,
  parameter int NS = 4,
  localparam int NV = NM * NS,
  localparam int MW = (NM > 1) ? $clog2(NM) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [MW-1:0] wr_mod,
  input  logic [1:0]    wr_reg,
  input  logic [31:0]   wr_data,
  input  logic [MW-1:0] rd_mod,
  input  logic [1:0]    rd_reg,
  output logic [31:0]   rd_data,
  input  logic [NV-1:0] cont_mode,
  input  logic [NV-1:0] seq_done,
  output logic [NV-1:0] start_pulse,
  output logic [NV-1:0] seq_busy,
  output logic [NM-1:0] mod_busy
);
  logic [NM-1:0] gs_flags;
  logic          rel_q;
  logic [31:0]   act_rd  [NM];
  logic [31:0]   init_rd [NM];
  logic [31:0]   ovr_rd  [NM];
  logic          unused_bits;

  assign unused_bits = ^wr_data;

  gsync_release #(.NM(NM)) u_rel (
    .clk     (clk),
    .rst_n   (rst_n),
    .gs_flags(gs_flags),
    .rel_q   (rel_q)
  );

  for (genvar m = 0; m < NM; m++) begin : g_mod
    gsync_module #(.NS(NS)) u_mod (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hit  (wr_en && (wr_mod == MW'(m))),
      .wr_reg  (wr_reg),
      .wr_start(wr_data[NS-1:0]),
      .wr_dma  (wr_data[DMA_OFS +: NS]),
      .wr_wait (wr_data[WAIT_BIT]),
      .wr_gs   (wr_data[GSYNC_BIT]),
      .cont    (cont_mode[m*NS +: NS]),
      .done    (seq_done[m*NS +: NS]),
      .rel_in  (rel_q),
      .gs_flag (gs_flags[m]),
      .act_rd  (act_rd[m]),
      .init_rd (init_rd[m]),
      .ovr_rd  (ovr_rd[m]),
      .pulse   (start_pulse[m*NS +: NS]),
      .busy    (seq_busy[m*NS +: NS]),
      .mod_busy(mod_busy[m])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int m = 0; m < NM; m++) begin
      if (rd_mod == MW'(m)) begin
        case (rd_reg)
          REG_ACT:  rd_data = act_rd[m];
          REG_INIT: rd_data = init_rd[m];
          REG_OVR:  rd_data = ovr_rd[m];
          default:  rd_data = '0;
        endcase
      end
    end
  end

  // R10
  mod_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy == '0) |-> (mod_busy == '0));
endmodule

// File: tb/sim_gsync_trig_ctrl.sv
module sim_gsync_trig_ctrl;
  localparam int NM = 2;
  localparam int NS = 4;
  localparam int NV = NM * NS;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [0:0] wr_mod = 0, rd_mod = 0;
  logic [1:0] wr_reg = 0, rd_reg = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic [NV-1:0] cont_mode = 8'h80, seq_done = 0, start_pulse, seq_busy;
  logic [NM-1:0] mod_busy;

  int cyc = 0, n_vec = 0, n_bad = 0;
  typedef struct { int at; logic [NV-1:0] v; } exp_t;
  exp_t q[$];

  gsync_trig_ctrl #(.NM(NM), .NS(NS)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mod(wr_mod), .wr_reg(wr_reg),
    .wr_data(wr_data), .rd_mod(rd_mod), .rd_reg(rd_reg), .rd_data(rd_data),
    .cont_mode(cont_mode), .seq_done(seq_done), .start_pulse(start_pulse),
    .seq_busy(seq_busy), .mod_busy(mod_busy));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: every cycle the pulse vector must match the queued item or be zero
  always @(negedge clk) begin
    if (rst_n) begin
      logic [NV-1:0] e;
      e = '0;
      if (q.size() > 0 && q[0].at == cyc) e = q.pop_front().v;
      chk("pulse", {24'b0, start_pulse}, {24'b0, e});
    end
  end

  task automatic exp_pulse(int at, logic [NV-1:0] v);
    exp_t x;
    x.at = at; x.v = v;
    q.push_back(x);
  endtask

  task automatic wr(int m, int r, logic [31:0] d);
    wr_en = 1; wr_mod = 1'(m); wr_reg = 2'(r); wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_data = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(int m, int r, output logic [31:0] d);
    rd_mod = 1'(m); rd_reg = 2'(r);
    #1 d = rd_data;
  endtask

  task automatic done_pulse(logic [NV-1:0] v);
    seq_done = v;
    @(negedge clk);
    seq_done = 0;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 pulse", {24'b0, start_pulse}, 0);
    chk("R1 busy", {24'b0, seq_busy}, 0);
    chk("R1 mod_busy", {30'b0, mod_busy}, 0);
    for (int m = 0; m < NM; m++)
      for (int r = 0; r < 3; r++) begin
        rd(m, r, d); chk("R1 regs", d, 0);
      end

    // R2 start on disabled sequencer ignored
    wr(0, 1, 32'h0000_0001);
    wr(0, 1, 32'h0800_0001);
    idle(2);
    rd(0, 1, d); chk("R2 not armed", d, 32'h0800_0000);
    wr(1, 1, 32'h8000_0000);          // release to flush the hold flag
    idle(3);
    rd(0, 1, d); chk("R2 flushed", d, 0);

    // R8 enable register layout
    wr(0, 0, 32'h0000_0101);
    rd(0, 0, d); chk("R8 0x101", d, 32'h0000_0101);
    wr(0, 0, 32'h0000_010F);
    wr(1, 0, 32'h0000_0007);
    rd(0, 0, d); chk("R8 mod0", d, 32'h0000_010F);
    rd(1, 0, d); chk("R8 mod1", d, 32'h0000_0007);

    // R3 immediate start on mod0 seq1
    exp_pulse(cyc + 1, 8'h02);
    wr(0, 1, 32'h0000_0002);
    #1;
    chk("R3 busy", {24'b0, seq_busy}, 32'h02);
    chk("R10 mod_busy", {30'b0, mod_busy}, 32'h1);
    done_pulse(8'h02);
    #1;
    chk("R10 busy cleared", {24'b0, seq_busy}, 0);

    // R4 arm with hold
    wr(0, 1, 32'h0800_0004);
    wr(1, 1, 32'h0800_0001);
    idle(2);
    rd(0, 1, d); chk("R4 mod0 held", d, 32'h0800_0004);
    rd(1, 1, d); chk("R4 mod1 held", d, 32'h0800_0001);

    // R5 release from mod1 carrying its own seq1
    exp_pulse(cyc + 3, 8'h34);
    wr(1, 1, 32'h8000_0002);
    rd(1, 1, d); chk("R4 release flag", d, 32'h8800_0003);
    idle(2);
    #1;
    chk("R5 busy", {24'b0, seq_busy}, 32'h34);
    chk("R10 both busy", {30'b0, mod_busy}, 32'h3);
    // R6 flags cleared
    rd(0, 1, d); chk("R6 mod0", d, 0);
    rd(1, 1, d); chk("R6 mod1", d, 0);
    done_pulse(8'h10);
    #1;
    chk("R10 partial", {30'b0, mod_busy}, 32'h3);
    done_pulse(8'h24);
    #1;
    chk("R10 idle", {30'b0, mod_busy}, 0);

    // R7 disable clears a held start
    wr(0, 1, 32'h0800_0008);
    wr(0, 0, 32'h0000_0107);
    rd(0, 1, d); chk("R7 cleared", d, 32'h0800_0000);
    wr(1, 1, 32'h8000_0000);
    idle(3);
    rd(0, 1, d); chk("R7 after release", d, 0);
    wr(0, 0, 32'h0000_010F);

    // R5 release coinciding with an immediate start in another module
    wr(0, 1, 32'h0800_0002);
    exp_pulse(cyc + 3, 8'h42);
    wr(0, 1, 32'h8000_0000);
    idle(1);
    wr(1, 1, 32'h0000_0004);
    idle(1);
    done_pulse(8'h42);

    // R11 overrun
    exp_pulse(cyc + 1, 8'h01);
    wr(0, 1, 32'h0000_0001);
    exp_pulse(cyc + 1, 8'h01);
    wr(0, 1, 32'h0000_0001);
    rd(0, 2, d); chk("R11 overrun set", d, 32'h1);
    wr(0, 2, 32'h0000_0001);
    rd(0, 2, d); chk("R11 overrun cleared", d, 0);
    done_pulse(8'h01);

    // R9 continuous sequencer bypasses the hold (mod1 seq3)
    wr(1, 1, 32'h0800_0000);
    exp_pulse(cyc + 1, 8'h80);
    wr(1, 0, 32'h0000_000F);
    #1;
    chk("R9 busy", {24'b0, seq_busy}, 32'h80);
    idle(1);
    exp_pulse(cyc + 2, 8'h80);
    done_pulse(8'h80);
    idle(1);
    wr(1, 0, 32'h0000_0007);
    done_pulse(8'h80);
    idle(3);
    #1;
    chk("R9 stopped", {24'b0, seq_busy}, 0);

    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL pulse: actual %0d missing expected 0", q.size());
    end
    finish_run();
  end
endmodule